// File: doc/BRIEF.md
# HDLC Bit-Serial Transmit Framer

The block accepts host bytes into a small transmit queue and sends them out one bit per enabled clock as an HDLC stream. Each queued byte carries two tags. The end-of-packet tag marks the last data byte of a packet. The abort tag marks a byte that stands for a request to abandon the current packet.

In framed operation the serializer adds opening and closing flags, inserts a zero after five ones in the data and FCS fields, and appends a complemented CRC-16. When the queue runs dry mid-packet, or when an honoured abort tag reaches the head of the queue, the serializer sends an abort sequence. Packets that are queued back to back share a single flag between them. With the link idle, the line carries either continuous flags or continuous ones, as chosen by a control input.

A transparent mode sends the queued bytes as raw bits with no framing at all. The queue level and the full and empty flags keep working in that mode. Single-cycle pulses report each completed packet and each underrun.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While rst_ni is low, tx_bit_o is 1, fifo_level_o is 0, fifo_empty_o is 1, fifo_full_o is 0, and both pulse outputs are 0.
- R2: Each write (wr_i high) stores {abort, eop, data} and adds one to fifo_level_o, which saturates at DEPTH. A write while the queue is full and nothing leaves it in that cycle replaces the most recently written entry. fifo_full_o is high when level equals DEPTH; fifo_empty_o is high when level is 0.
- R3: On every clock with bit_en_i high, tx_bit_o takes the next line bit. Bytes go least significant bit first. A framed packet that starts from idle begins with the flag 0x7E, whose line order is 0,1,1,1,1,1,1,0.
- R4: Inside data bytes and the FCS, a 0 is sent after every five consecutive 1s. Flags, aborts, idle bytes and transparent bytes are never stuffed.
- R5: After a byte tagged eop, the serializer sends the 16-bit FCS and then a closing flag. The FCS is a reflected CRC-16 (polynomial 0x8408 in shift-right form, i.e. x^16+x^12+x^5+1), preset to 0xFFFF over the packet's data bits. It goes out complemented, least significant bit first.
- R6: If the queue is not empty and framed mode is selected when a closing flag ends, the next byte follows at once with no second flag.
- R7: eop_irq_o pulses for one clock on the bit step that follows the last bit of a closing flag.
- R8: When an abort-tagged byte reaches the head with at least two data bytes of the current packet already sent, that byte is dropped. The line then carries 0 followed by seven 1s, and the link returns to idle. A later packet starts with its own opening flag.
- R9: An abort-tagged byte that reaches the head with fewer than two data bytes of the packet sent is sent as an ordinary data byte; its eop tag still applies.
- R10: If the queue is empty when an untagged data byte ends, the line carries 0 followed by seven 1s and the link returns to idle. underrun_irq_o pulses on the step that emits that first 0.
- R11: Each idle byte is chosen when it is loaded: flags when idle_flags_i is 1, all ones when it is 0.
- R12: When transp_i is high and no packet is open, queued bytes are sent raw, least significant bit first, with no flags, stuffing or FCS. The idle fill is then all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the queue |
| wr_data_i | input | 8 | Byte to queue |
| wr_eop_i | input | 1 | Byte ends its packet |
| wr_abort_i | input | 1 | Byte requests a packet abort |
| bit_en_i | input | 1 | Bit-clock enable; one line bit per high cycle |
| transp_i | input | 1 | Transparent (unframed) mode |
| idle_flags_i | input | 1 | Idle fill: 1 flags, 0 ones |
| tx_bit_o | output | 1 | Serial line bit |
| fifo_empty_o | output | 1 | Queue empty |
| fifo_full_o | output | 1 | Queue full |
| fifo_level_o | output | $clog2(DEPTH+1) | Queue occupancy |
| eop_irq_o | output | 1 | Packet-complete pulse |
| underrun_irq_o | output | 1 | Underrun pulse |

## Verification
tx_bit_o and both pulse outputs are registered at the same rising edge on which bit_en_i is sampled high. The first bit of a newly chosen unit therefore appears one edge after the step that picks it, and the last bit of the previous unit is already on the line. fifo_level_o and the full and empty flags reflect a write or a pop one edge after the cycle in which it happens. The reference model advances at each rising edge from the inputs sampled there, and every output is compared on the following falling edge, so each expected value is taken exactly one register stage after its cause.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    K_IDLE, K_OPEN, K_DATA, K_FCS, K_CLOSE, K_ABORT, K_RAW
  } unit_e;

  typedef struct packed {
    logic       abort;
    logic       eop;
    logic [7:0] data;
  } entry_t;

  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE = 8'hFE; // 0 first, then seven ones
  localparam logic [7:0]  ONES_BYTE  = 8'hFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  entry_t        wr_entry_i,
  input  logic          pop_i,
  output entry_t        head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  entry_t        mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, last_ptr;
  logic [LW-1:0] count_q;
  logic          push, ovw;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o  = (count_q == '0);
  assign full_o   = (count_q == LW'(DEPTH));
  assign level_o  = count_q;
  assign head_o   = mem_q[rd_ptr_q];
  assign push     = wr_i && (!full_o || pop_i);
  assign ovw      = wr_i && full_o && !pop_i;
  assign last_ptr = (wr_ptr_q == '0) ? AW'(DEPTH - 1) : wr_ptr_q - 1'b1;

  always_ff @(posedge clk_i) begin
    if (push)     mem_q[wr_ptr_q] <= wr_entry_i;
    else if (ovw) mem_q[last_ptr] <= wr_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push)  wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      count_q <= count_q + LW'(push) - LW'(pop_i);
    end
  end

  assert_ovw_keeps_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !pop_i) |=> $stable(count_q));
  assert_no_pop_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic [15:0] crc_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  always_comb begin
    crc_o = {1'b0, crc_i[15:1]};
    if (crc_i[0] ^ bit_i) crc_o = crc_o ^ CRC_POLY_R;
  end
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_en_i,
  input  logic   transp_i,
  input  logic   idle_flags_i,
  input  entry_t head_i,
  input  logic   empty_i,
  output logic   pop_o,
  output logic   tx_bit_o,
  output logic   eop_irq_o,
  output logic   und_irq_o
);
  unit_e       kind_q, n_kind, cur_kind, idle_kind;
  logic [15:0] sh_q, n_sh, cur_sh, sh_n;
  logic [15:0] crc_q, crc_base, crc_step, crc_n;
  logic [4:0]  left_q, cur_left, left_n;
  logic [2:0]  ones_q, ones_n;
  logic [1:0]  sent_q, sent_n;
  logic        last_eop_q, last_eop_n;
  logic        stuff_now, ld, bit_out, pop_req, idle_pop, eop_ev, und_ev;

  assign stuff_now = (kind_q inside {K_DATA, K_FCS}) && (ones_q == 3'd5);
  assign ld        = (left_q == '0) && !stuff_now;
  assign idle_kind = empty_i ? K_IDLE : (transp_i ? K_RAW : K_OPEN);
  assign idle_pop  = !empty_i && transp_i;

  // choose the next unit when the current one is exhausted
  always_comb begin
    n_kind  = kind_q;
    pop_req = 1'b0;
    eop_ev  = 1'b0;
    und_ev  = 1'b0;
    if (ld) begin
      case (kind_q)
        K_OPEN: begin n_kind = K_DATA; pop_req = 1'b1; end
        K_DATA: begin
          if (last_eop_q) n_kind = K_FCS;
          else if (empty_i) begin n_kind = K_ABORT; und_ev = 1'b1; end
          else if (head_i.abort && sent_q == 2'd2) begin n_kind = K_ABORT; pop_req = 1'b1; end
          else begin n_kind = K_DATA; pop_req = 1'b1; end
        end
        K_FCS: n_kind = K_CLOSE;
        K_CLOSE: begin
          eop_ev = 1'b1;
          if (!empty_i && !transp_i) begin n_kind = K_DATA; pop_req = 1'b1; end
          else begin n_kind = idle_kind; pop_req = idle_pop; end
        end
        default: begin n_kind = idle_kind; pop_req = idle_pop; end
      endcase
    end
  end

  always_comb begin
    case (n_kind)
      K_DATA, K_RAW: n_sh = {8'h00, head_i.data};
      K_FCS:         n_sh = ~crc_q;
      K_ABORT:       n_sh = {8'h00, ABORT_BYTE};
      K_IDLE:        n_sh = {8'h00, (transp_i || !idle_flags_i) ? ONES_BYTE : FLAG_BYTE};
      default:       n_sh = {8'h00, FLAG_BYTE};
    endcase
  end

  assign cur_kind = ld ? n_kind : kind_q;
  assign cur_sh   = ld ? n_sh : sh_q;
  assign cur_left = ld ? ((n_kind == K_FCS) ? 5'd16 : 5'd8) : left_q;
  assign crc_base = (ld && (n_kind inside {K_OPEN, K_CLOSE, K_ABORT})) ? CRC_INIT : crc_q;

  hdlc_tx_crc u_crc (.crc_i(crc_base), .bit_i(cur_sh[0]), .crc_o(crc_step));

  always_comb begin
    if (stuff_now) begin
      bit_out = 1'b0;
      sh_n    = sh_q;
      left_n  = left_q;
      ones_n  = '0;
      crc_n   = crc_q;
    end else begin
      bit_out = cur_sh[0];
      sh_n    = cur_sh >> 1;
      left_n  = cur_left - 5'd1;
      ones_n  = ((cur_kind inside {K_DATA, K_FCS}) && bit_out) ? ones_q + 3'd1 : '0;
      crc_n   = (cur_kind == K_DATA) ? crc_step : crc_base;
    end
    sent_n = sent_q;
    if (ld) begin
      if (n_kind == K_DATA) sent_n = (sent_q == 2'd2) ? 2'd2 : sent_q + 2'd1;
      else if (n_kind inside {K_OPEN, K_CLOSE, K_ABORT}) sent_n = '0;
    end
    last_eop_n = (ld && n_kind == K_DATA) ? head_i.eop : last_eop_q;
  end

  assign pop_o = bit_en_i && pop_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q     <= K_IDLE;
      sh_q       <= '0;
      left_q     <= '0;
      ones_q     <= '0;
      crc_q      <= CRC_INIT;
      sent_q     <= '0;
      last_eop_q <= 1'b0;
      tx_bit_o   <= 1'b1;
      eop_irq_o  <= 1'b0;
      und_irq_o  <= 1'b0;
    end else begin
      eop_irq_o <= bit_en_i && eop_ev;
      und_irq_o <= bit_en_i && und_ev;
      if (bit_en_i) begin
        kind_q     <= cur_kind;
        sh_q       <= sh_n;
        left_q     <= left_n;
        ones_q     <= ones_n;
        crc_q      <= crc_n;
        sent_q     <= sent_n;
        last_eop_q <= last_eop_n;
        tx_bit_o   <= bit_out;
      end
    end
  end

  assert_und_starts_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_irq_o |-> !tx_bit_o);
  assert_eop_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_irq_o |=> !eop_irq_o);
  assert_irq_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eop_irq_o && und_irq_o));
  assert_ones_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 3'd5);
  assert_raw_no_stuff_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_RAW) |-> (ones_q == '0));
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_eop_i,
  input  logic          wr_abort_i,
  input  logic          bit_en_i,
  input  logic          transp_i,
  input  logic          idle_flags_i,
  output logic          tx_bit_o,
  output logic          fifo_empty_o,
  output logic          fifo_full_o,
  output logic [LW-1:0] fifo_level_o,
  output logic          eop_irq_o,
  output logic          underrun_irq_o
);
  entry_t wr_entry, head;
  logic   pop;

  assign wr_entry = '{abort: wr_abort_i, eop: wr_eop_i, data: wr_data_i};

  hdlc_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_entry_i(wr_entry),
    .pop_i     (pop),
    .head_o    (head),
    .empty_o   (fifo_empty_o),
    .full_o    (fifo_full_o),
    .level_o   (fifo_level_o)
  );

  hdlc_tx_ser u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .transp_i    (transp_i),
    .idle_flags_i(idle_flags_i),
    .head_i      (head),
    .empty_i     (fifo_empty_o),
    .pop_o       (pop),
    .tx_bit_o    (tx_bit_o),
    .eop_irq_o   (eop_irq_o),
    .und_irq_o   (underrun_irq_o)
  );
endmodule

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int MI = 0, MO = 1, MD = 2, MF = 3, MC = 4, MA = 5, MR = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, eop_in = 1'b0, abt_in = 1'b0, bit_en = 1'b0;
  logic transp = 1'b0, idle_fl = 1'b1;
  logic [7:0] wdata = '0;
  logic tx_bit, f_empty, f_full, eop_irq, und_irq;
  logic [LW-1:0] level;

  hdlc_tx_framer #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdata),
    .wr_eop_i(eop_in), .wr_abort_i(abt_in), .bit_en_i(bit_en),
    .transp_i(transp), .idle_flags_i(idle_fl), .tx_bit_o(tx_bit),
    .fifo_empty_o(f_empty), .fifo_full_o(f_full), .fifo_level_o(level),
    .eop_irq_o(eop_irq), .underrun_irq_o(und_irq)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0, run_chk = 1'b0;
  int en_mode = 0, en_cnt = 0;

  // reference model state
  bit          mq[$];
  string       mt[$];
  logic [9:0]  mf[$];
  logic [9:0]  m_e;
  int          mkind = MI, mones = 0, msent = 0;
  logic [15:0] mcrc = 16'hFFFF;
  bit          mlast = 1'b0, m_popped, full_pre;
  bit          exp_bit = 1'b1, exp_eop = 1'b0, exp_und = 1'b0;
  string       cur_tag = "R11";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push_bits(input logic [15:0] v, input int n, input bit stf,
                           input bit upd, input string tag);
    for (int i = 0; i < n; i++) begin
      bit b;
      b = v[i];
      mq.push_back(b);
      mt.push_back(tag);
      if (upd) mcrc = {1'b0, mcrc[15:1]} ^ (((mcrc[0] ^ b) != 1'b0) ? 16'h8408 : 16'h0000);
      if (stf) begin
        if (b) mones++; else mones = 0;
        if (mones == 5) begin mq.push_back(1'b0); mt.push_back("R4"); mones = 0; end
      end
    end
  endtask

  task automatic m_take(input string tag);
    m_e = mf.pop_front();
    m_popped = 1'b1;
    if (msent < 2) msent++;
    mlast = m_e[8];
    mkind = MD;
    push_bits({8'h00, m_e[7:0]}, 8, 1'b1, 1'b1, m_e[9] ? "R9" : tag);
  endtask

  task automatic m_flag(input int k, input string tag);
    mkind = k; mcrc = 16'hFFFF; msent = 0; mones = 0;
    push_bits(16'h007E, 8, 1'b0, 1'b0, tag);
  endtask

  task automatic m_abort(input string tag);
    mkind = MA; mcrc = 16'hFFFF; msent = 0; mones = 0;
    push_bits(16'h00FE, 8, 1'b0, 1'b0, tag);
  endtask

  task automatic m_idle();
    if (mf.size() > 0) begin
      if (transp) begin
        m_e = mf.pop_front(); m_popped = 1'b1; mkind = MR; mones = 0;
        push_bits({8'h00, m_e[7:0]}, 8, 1'b0, 1'b0, "R12");
      end else m_flag(MO, "R3");
    end else begin
      mkind = MI; mones = 0;
      push_bits((transp || !idle_fl) ? 16'h00FF : 16'h007E, 8, 1'b0, 1'b0,
                transp ? "R12" : "R11");
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mt.delete(); mf.delete();
      mkind = MI; mones = 0; msent = 0; mcrc = 16'hFFFF; mlast = 1'b0;
      exp_bit = 1'b1; exp_eop = 1'b0; exp_und = 1'b0;
    end else begin
      exp_eop = 1'b0; exp_und = 1'b0; m_popped = 1'b0;
      full_pre = (mf.size() == DEPTH);
      if (bit_en) begin
        if (mq.size() == 0) begin
          case (mkind)
            MO: m_take("R3");
            MD: begin
              if (mlast) begin mkind = MF; push_bits(~mcrc, 16, 1'b1, 1'b0, "R5"); end
              else if (mf.size() == 0) begin m_abort("R10"); exp_und = 1'b1; end
              else if (mf[0][9] && msent >= 2) begin
                void'(mf.pop_front()); m_popped = 1'b1; m_abort("R8");
              end else m_take("R3");
            end
            MF: m_flag(MC, "R5");
            MC: begin
              exp_eop = 1'b1;
              if (mf.size() > 0 && !transp) m_take("R6");
              else m_idle();
            end
            default: m_idle();
          endcase
        end
        exp_bit = mq.pop_front();
        cur_tag = mt.pop_front();
      end
      if (wr) begin
        if (!full_pre || m_popped) mf.push_back({abt_in, eop_in, wdata});
        else mf[mf.size() - 1] = {abt_in, eop_in, wdata};
      end
    end
  end

  always @(negedge clk) begin
    en_cnt = (en_cnt + 1) % 3;
    case (en_mode)
      0: bit_en <= 1'b1;
      1: bit_en <= (en_cnt == 0);
      default: bit_en <= 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && run_chk && !done) begin
      chk(tx_bit === exp_bit, cur_tag, int'(tx_bit), int'(exp_bit));
      chk(int'(level) == mf.size() && f_full == (mf.size() == DEPTH) &&
          f_empty == (mf.size() == 0), "R2", int'(level), mf.size());
      chk(eop_irq === exp_eop, "R7", int'(eop_irq), int'(exp_eop));
      chk(und_irq === exp_und, "R10", int'(und_irq), int'(exp_und));
    end
  end

  task automatic put_raw(input logic [7:0] d, input bit e, input bit a);
    wr = 1'b1; wdata = d; eop_in = e; abt_in = a;
    @(negedge clk);
    wr = 1'b0; eop_in = 1'b0; abt_in = 1'b0;
  endtask

  task automatic put(input logic [7:0] d, input bit e, input bit a);
    while (mf.size() == DEPTH) @(negedge clk);
    put_raw(d, e, a);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_bit === 1'b1, "R1", int'(tx_bit), 1);
    chk(level == '0 && f_empty && !f_full, "R1", int'(level), 0);
    chk(!eop_irq && !und_irq, "R1", int'(eop_irq | und_irq), 0);
    rst_n = 1'b1;
    run_chk = 1'b1;
    en_mode = 0; idle_fl = 1'b1;
    settle(40);                              // R11 flag fill
    idle_fl = 1'b0;
    settle(30);                              // R11 ones fill
    put(8'hFF, 0, 0); put(8'h3E, 0, 0); put(8'h81, 1, 0);   // R4 R5
    settle(150);
    en_mode = 1;                             // R6 shared flag
    put(8'h55, 0, 0); put(8'hF8, 1, 0); put(8'h1F, 0, 0); put(8'h7E, 1, 0);
    settle(400);
    en_mode = 0; idle_fl = 1'b1;             // R8 honoured abort
    put(8'h01, 0, 0); put(8'h02, 0, 0); put(8'h03, 0, 0);
    put(8'hAA, 0, 1); put(8'h44, 1, 0);
    settle(200);
    put(8'h5A, 0, 1); put(8'h6B, 1, 0);      // R9 abort tag ignored
    settle(150);
    put(8'h11, 0, 0); put(8'h22, 0, 0);      // R10 underrun
    settle(150);
    en_mode = 2;                             // R2 overwrite on full
    settle(10);
    put_raw(8'hC1, 0, 0); put_raw(8'hC2, 0, 0); put_raw(8'hC3, 0, 0);
    put_raw(8'hC4, 0, 0); put_raw(8'hC5, 1, 0);
    chk(int'(level) == DEPTH && f_full, "R2", int'(level), DEPTH);
    en_mode = 0;
    settle(200);
    transp = 1'b1;                           // R12 transparent
    settle(20);
    put(8'hA5, 0, 0); put(8'h0F, 0, 0); put(8'hFF, 1, 0);
    settle(60);
    transp = 1'b0;
    settle(40);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule